// File: doc/BRIEF.md
# Ingress Queue Occupancy and Dispatch Request Unit

This unit sits in one ingress module of a three-stage switch whose first and last stages are buffered and whose middle stage is bufferless. It keeps one occupancy counter per egress module, standing for the queue of cells held for that destination. Each clock cycle is one time slot. In every slot the unit builds a request word for a central matching arbiter from the counter values. That word flags the destinations whose backlog justifies a bulk transfer through the middle stage, and it carries one bit of urgency.

The arbiter answers in the same slot with at most one granted destination. The unit then reports, per destination, how many cells leave its queue in that slot. Every non-empty queue drains one cell over its dedicated direct link. A granted queue drains a full batch instead: its direct-link cell plus one cell per middle-stage module. Per-port arrival strobes carry a destination index and raise the counters at the end of the slot.

Top module: `vomq_req_gen`

## Requirements
- R1: After reset every counter is zero, so `req_valid` is 0, `req_vec` is all zeros and every departure count is 0.
- R2: Destination index j (0-based) is flagged in `req_vec` bit j+1, and only while its counter holds at least `N_MOD` cells.
- R3: When any counter holds at least `K_MULT*N_MOD` cells, `req_vec` bit 0 is 1 and exactly the destinations at or above that level are flagged.
- R4: When no counter reaches `K_MULT*N_MOD` but some hold at least `N_MOD`, bit 0 is 0 and exactly the destinations with counts in [N_MOD, K_MULT*N_MOD) are flagged (for example, with N_MOD=8 and destinations 1 and 3 flagged, the word is 9'b000010100).
- R5: When no counter reaches `N_MOD`, `req_valid` is 0 and `req_vec` is all zeros.
- R6: A non-empty queue that is not granted reports exactly 1 departing cell in the slot. An empty queue reports 0.
- R7: A grant (`grant_vld`=1, `grant_dest`=j) for a destination flagged in the current `req_vec` makes queue j report min(count, N_MOD) departing cells in that slot.
- R8: A grant for a destination not flagged in the current `req_vec` is ignored, and that queue reports only its direct-link departure.
- R9: At each clock edge a counter becomes count − departures + arrivals for that destination, with arrivals and departures in the same slot both applied.
- R10: A counter saturates at 2^CNT_W−1 and further arrivals are dropped. Departures never take it below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_vld | input | N_MOD | Per-input-port cell arrival strobe |
| arr_dest | input | N_MOD*IDX_W | Destination index per input port, port p in bits [p*IDX_W +: IDX_W] |
| grant_vld | input | 1 | Arbiter grant present in this slot |
| grant_dest | input | IDX_W | Granted destination index |
| req_valid | output | 1 | At least one destination flagged |
| req_vec | output | N_MOD+1 | Request word: bit 0 priority, bit j+1 destination j |
| dep_cnt | output | N_MOD*DEP_W | Cells leaving queue j this slot, in bits [j*DEP_W +: DEP_W] |

## Verification
The assertions assume that the arbiter answers within the slot in which the request is visible, and that a destination index is only meaningful below `N_MOD`. The stimulus changes arrivals and grants half a cycle before each edge, so grants always refer to the request presented in that slot. Grants are aimed both at flagged and at unflagged destinations. Arrival destinations are biased toward one hot queue so that the high band and saturation are reached, while the other queues hover around the low threshold.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_LOW  = 2'd1,
        REQ_HIGH = 2'd2
    } req_class_e;
endpackage

// File: rtl/vrg_arr_tally.sv
module vrg_arr_tally #(
    parameter int N_MOD = 4,
    parameter int IDX_W = 2,
    parameter int TAL_W = 3
) (
    input  logic [N_MOD-1:0]       arr_vld,
    input  logic [N_MOD*IDX_W-1:0] arr_dest,
    output logic [N_MOD*TAL_W-1:0] tally
);
    for (genvar d = 0; d < N_MOD; d++) begin : g_dest
        logic [TAL_W-1:0] cnt_d;
        always_comb begin
            cnt_d = '0;
            for (int p = 0; p < N_MOD; p++) begin
                if (arr_vld[p] && (arr_dest[p*IDX_W +: IDX_W] == IDX_W'(d))) begin
                    cnt_d = cnt_d + TAL_W'(1);
                end
            end
        end
        assign tally[d*TAL_W +: TAL_W] = cnt_d;
    end
endmodule

// File: rtl/vrg_occ_slice.sv
module vrg_occ_slice #(
    parameter int N_MOD = 4,
    parameter int CNT_W = 5,
    parameter int DEP_W = 3,
    parameter int TAL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAL_W-1:0] arrivals,
    input  logic             bulk_hit,
    output logic [CNT_W-1:0] occ,
    output logic [DEP_W-1:0] dep
);
    localparam int SW = CNT_W + 1;
    localparam logic [SW-1:0] CNT_MAX = SW'((1 << CNT_W) - 1);
    localparam logic [CNT_W-1:0] BATCH = CNT_W'(N_MOD);

    typedef struct packed {
        logic [CNT_W-1:0] occ;
    } slice_st_t;

    slice_st_t st_q, st_d;
    logic [DEP_W-1:0] dep_c;
    logic [SW-1:0]    rem_c, sum_c;

    always_comb begin
        st_d = st_q;
        if (st_q.occ == '0) begin
            dep_c = '0;
        end else if (bulk_hit) begin
            dep_c = (st_q.occ < BATCH) ? DEP_W'(st_q.occ) : DEP_W'(N_MOD);
        end else begin
            dep_c = DEP_W'(1);
        end
        rem_c = {1'b0, st_q.occ} - SW'(dep_c);
        sum_c = rem_c + SW'(arrivals);
        st_d.occ = (sum_c > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum_c[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ = st_q.occ;
    assign dep = dep_c;
endmodule

// File: rtl/vrg_req_build.sv
module vrg_req_build
    import vrg_pkg::*;
#(
    parameter int N_MOD  = 4,
    parameter int K_MULT = 2,
    parameter int CNT_W  = 5,
    parameter int IDX_W  = 2
) (
    input  logic [N_MOD*CNT_W-1:0] occ_flat,
    input  logic                   grant_vld,
    input  logic [IDX_W-1:0]       grant_dest,
    output logic                   req_valid,
    output logic [N_MOD:0]         req_vec,
    output logic [N_MOD-1:0]       bulk_hit
);
    localparam logic [CNT_W-1:0] LO_THR = CNT_W'(N_MOD);
    localparam logic [CNT_W-1:0] HI_THR = CNT_W'(K_MULT * N_MOD);

    logic [N_MOD-1:0] elig, urgent;
    req_class_e       cls;

    for (genvar j = 0; j < N_MOD; j++) begin : g_cmp
        assign elig[j]   = occ_flat[j*CNT_W +: CNT_W] >= LO_THR;
        assign urgent[j] = occ_flat[j*CNT_W +: CNT_W] >= HI_THR;
    end

    always_comb begin
        if (|urgent)    cls = REQ_HIGH;
        else if (|elig) cls = REQ_LOW;
        else            cls = REQ_NONE;
        case (cls)
            REQ_HIGH: req_vec = {urgent, 1'b1};
            REQ_LOW:  req_vec = {elig, 1'b0};
            default:  req_vec = '0;
        endcase
        req_valid = (cls != REQ_NONE);
    end

    for (genvar j = 0; j < N_MOD; j++) begin : g_hit
        assign bulk_hit[j] = grant_vld && (grant_dest == IDX_W'(j)) && req_vec[j+1];
    end
endmodule

// File: rtl/vomq_req_gen.sv
module vomq_req_gen #(
    parameter int N_MOD  = 4,
    parameter int K_MULT = 2,
    parameter int CNT_W  = 5,
    parameter int IDX_W  = (N_MOD > 1) ? $clog2(N_MOD) : 1,
    parameter int DEP_W  = $clog2(N_MOD + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_MOD-1:0]       arr_vld,
    input  logic [N_MOD*IDX_W-1:0] arr_dest,
    input  logic                   grant_vld,
    input  logic [IDX_W-1:0]       grant_dest,
    output logic                   req_valid,
    output logic [N_MOD:0]         req_vec,
    output logic [N_MOD*DEP_W-1:0] dep_cnt
);
    localparam int TAL_W = $clog2(N_MOD + 1);

    logic [N_MOD*TAL_W-1:0] tally;
    logic [N_MOD*CNT_W-1:0] occ_flat;
    logic [N_MOD-1:0]       bulk_hit;

    vrg_arr_tally #(.N_MOD(N_MOD), .IDX_W(IDX_W), .TAL_W(TAL_W)) tally_i (
        .arr_vld (arr_vld),
        .arr_dest(arr_dest),
        .tally   (tally)
    );

    for (genvar j = 0; j < N_MOD; j++) begin : g_q
        vrg_occ_slice #(.N_MOD(N_MOD), .CNT_W(CNT_W), .DEP_W(DEP_W), .TAL_W(TAL_W)) slice_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .arrivals(tally[j*TAL_W +: TAL_W]),
            .bulk_hit(bulk_hit[j]),
            .occ     (occ_flat[j*CNT_W +: CNT_W]),
            .dep     (dep_cnt[j*DEP_W +: DEP_W])
        );
    end

    vrg_req_build #(.N_MOD(N_MOD), .K_MULT(K_MULT), .CNT_W(CNT_W), .IDX_W(IDX_W)) build_i (
        .occ_flat  (occ_flat),
        .grant_vld (grant_vld),
        .grant_dest(grant_dest),
        .req_valid (req_valid),
        .req_vec   (req_vec),
        .bulk_hit  (bulk_hit)
    );
endmodule

// File: rtl/vomq_req_gen_chk.sv
module vomq_req_gen_chk #(
    parameter int N_MOD = 4,
    parameter int IDX_W = 2,
    parameter int DEP_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   grant_vld,
    input logic [IDX_W-1:0]       grant_dest,
    input logic                   req_valid,
    input logic [N_MOD:0]         req_vec,
    input logic [N_MOD*DEP_W-1:0] dep_cnt
);
    logic [N_MOD-1:0] bulk_mask;
    for (genvar j = 0; j < N_MOD; j++) begin : g_m
        assign bulk_mask[j] = dep_cnt[j*DEP_W +: DEP_W] > DEP_W'(1);
    end

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !req_valid);

    // R5
    no_req_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (req_vec == '0));

    // R3
    high_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vec[0] |-> (req_vec[N_MOD:1] != '0));

    // R7
    single_batch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bulk_mask) <= 1);

    for (genvar j = 0; j < N_MOD; j++) begin : g_a
        // R8
        batch_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bulk_mask[j] |-> (grant_vld && grant_dest == IDX_W'(j) && req_vec[j+1]));
    end
endmodule

bind vomq_req_gen vomq_req_gen_chk #(.N_MOD(N_MOD), .IDX_W(IDX_W), .DEP_W(DEP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_vld (grant_vld),
    .grant_dest(grant_dest),
    .req_valid (req_valid),
    .req_vec   (req_vec),
    .dep_cnt   (dep_cnt)
);

// File: tb/vomq_req_gen_tb.sv
module vomq_req_gen_tb_top;
    localparam int N = 4;
    localparam int K = 2;
    localparam int CW = 5;
    localparam int IW = 2;
    localparam int DW = 3;
    localparam int CLK_PERIOD = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] arr_vld = '0;
    logic [N*IW-1:0] arr_dest = '0;
    logic grant_vld = 1'b0;
    logic [IW-1:0] grant_dest = '0;
    logic req_valid;
    logic [N:0] req_vec;
    logic [N*DW-1:0] dep_cnt;

    int checks = 0;
    int errors = 0;
    int occ_m [N];
    logic [N:0] seen_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    vomq_req_gen #(.N_MOD(N), .K_MULT(K), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_dest(arr_dest),
        .grant_vld(grant_vld), .grant_dest(grant_dest),
        .req_valid(req_valid), .req_vec(req_vec), .dep_cnt(dep_cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_req();
        int v = 0;
        bit hi = 0;
        for (int j = 0; j < N; j++) if (occ_m[j] >= K*N) hi = 1;
        for (int j = 0; j < N; j++) begin
            if (hi && occ_m[j] >= K*N) v |= (1 << (j+1));
            if (!hi && occ_m[j] >= N) v |= (1 << (j+1));
        end
        if (hi) v |= 1;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; arr_vld = '0; grant_vld = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < N; j++) occ_m[j] = 0;
    endtask

    task automatic slot(input logic [N-1:0] av, input logic [N*IW-1:0] ad,
                        input logic gv, input logic [IW-1:0] gd);
        int er, hit, ed, tag_sel;
        int tal [N];
        @(negedge clk);
        arr_vld = av; arr_dest = ad; grant_vld = gv; grant_dest = gd;
        #1;
        er = exp_req();
        seen_vec = req_vec;
        if (er == 0)          check("R5 req_vec", int'(req_vec), er);
        else if (er & 1)      check("R3 req_vec", int'(req_vec), er);
        else                  check("R4/R2 req_vec", int'(req_vec), er);
        check("R5 req_valid", int'(req_valid), int'(er != 0));
        for (int j = 0; j < N; j++) begin
            hit = (gv && int'(gd) == j && ((er >> (j+1)) & 1)) ? 1 : 0;
            if (occ_m[j] == 0) ed = 0;
            else if (hit != 0) ed = (occ_m[j] < N) ? occ_m[j] : N;
            else ed = 1;
            tag_sel = hit ? 7 : ((gv && int'(gd) == j) ? 8 : 6);
            if (tag_sel == 7)      check("R7 dep", int'(dep_cnt[j*DW +: DW]), ed);
            else if (tag_sel == 8) check("R8 dep", int'(dep_cnt[j*DW +: DW]), ed);
            else                   check("R6 dep", int'(dep_cnt[j*DW +: DW]), ed);
            tal[j] = -ed;
        end
        for (int p = 0; p < N; p++) if (av[p]) tal[int'(ad[p*IW +: IW])]++;
        @(posedge clk);
        for (int j = 0; j < N; j++) begin
            occ_m[j] = occ_m[j] + tal[j];
            if (occ_m[j] > CMAX) occ_m[j] = CMAX;
        end
    endtask

    function automatic logic [N*IW-1:0] all_to(input int d);
        logic [N*IW-1:0] r;
        for (int p = 0; p < N; p++) r[p*IW +: IW] = IW'(d);
        return r;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int cnt;
        logic [N*IW-1:0] ad;
        int hot;
        void'($urandom(32'd2024));
        do_reset();
        // R1: reset state visible at the ports
        #1;
        check("R1 req_valid", int'(req_valid), 0);
        check("R1 req_vec", int'(req_vec), 0);
        check("R1 dep_cnt", int'(dep_cnt), 0);

        // R9: arrival and departure on the same counter in one slot
        slot(4'b1111, all_to(1), 1'b0, '0);
        slot(4'b0001, all_to(1), 1'b0, '0);
        slot(4'b0000, '0, 1'b0, '0);
        check("R9 flag kept", int'(seen_vec), 4);

        // R8: grant to an unflagged non-empty queue is ignored
        slot(4'b0011, all_to(2), 1'b0, '0);
        slot(4'b0000, '0, 1'b1, 2'd2);
        check("R8 dep of unflagged", int'(dep_cnt[2*DW +: DW]), 1);
        // R7: grant to flagged queue
        slot(4'b0000, '0, 1'b1, 2'd1);

        // R10: saturate then drain in batches
        do_reset();
        for (int t = 0; t < 20; t++) slot(4'b1111, all_to(0), 1'b0, '0);
        cnt = 0;
        for (int t = 0; t < 20; t++) begin
            slot(4'b0000, '0, 1'b1, 2'd0);
            if (seen_vec[1]) cnt++;
            else break;
        end
        check("R10 batches before drop", cnt, 7);

        // random phase
        do_reset();
        hot = 0;
        for (int t = 0; t < 1500; t++) begin
            if (t % 200 == 0) hot = $urandom % N;
            for (int p = 0; p < N; p++)
                ad[p*IW +: IW] = ($urandom % 3 == 0) ? IW'($urandom % N) : IW'(hot);
            slot(N'($urandom), ad, ($urandom % 10) < 3, IW'($urandom % N));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule